// File: doc/BRIEF.md
# Raster Timing Generator with Vertical-Blank Interrupt

This block produces the frame timing for a video processor. A dot counter counts the pixel positions of a scanline and a line counter counts the scanlines of a frame. The block decodes the counters into a flag for the visible picture area and a flag for the vertical blanking region. The CPU side can use the blanking flag to decide when video memory is free for it to access.

When the raster reaches the second dot of scanline 241, a sticky vblank status bit is set. The bit is cleared when the frame's last line begins, or when the CPU reads the status register. An active-low interrupt request output stays low while the status bit and the interrupt-enable bit of the control register are both true. As a result, enabling the interrupt during blanking raises the request at once.

Top module: `raster_timing`

## Requirements
- R1: While `rst_n` is low, `dot` and `line` are 0, `vbl_status` is 0 and `nmi_n` is 1.
- R2: `dot` advances by one per clock from 0 to 340, then returns to 0. `line` increments in the same cycle that `dot` returns to 0.
- R3: When `dot` returns to 0 after line 261, `line` returns to 0. A frame is therefore 262 x 341 clocks.
- R4: `visible` is 1 exactly when `dot` < 256 and `line` <= 240.
- R5: `vblank` is 1 exactly when `line` >= 241.
- R6: `vbl_status` is 1 in the cycle whose counters show line 241, dot 1. This holds even if `status_rd` was high in the cycle before.
- R7: `vbl_status` is 0 from the cycle whose counters show line 261, dot 0, until the next set point.
- R8: A high `status_rd` in any cycle other than line 241, dot 0 makes `vbl_status` 0 in the next cycle.
- R9: `nmi_n` is 0 exactly when `vbl_status` and `nmi_enable` are both 1, with no register delay. Raising `nmi_enable` while `vbl_status` is 1 drives `nmi_n` low in the same cycle.
- R10: A `status_rd` pulse outside the blanking period has no effect: `vbl_status` stays 0 and the counters are undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_enable | input | 1 | Interrupt enable, bit 7 of the control register |
| status_rd | input | 1 | One-cycle pulse per CPU read of the status register |
| dot | output | 9 | Current dot within the scanline (0..340) |
| line | output | 9 | Current scanline within the frame (0..261) |
| visible | output | 1 | Current position lies in the visible picture |
| vblank | output | 1 | Current line lies in the vertical blanking region |
| vbl_status | output | 1 | Sticky vertical-blank status bit |
| nmi_n | output | 1 | Active-low interrupt request to the CPU |

## Verification
A wrong dot or line count appears on the `dot`, `line`, `visible` and `vblank` ports in the very cycle it occurs, because the bench compares them against its own model on every clock. An error in the status bit's priority or timing appears on `vbl_status` and on `nmi_n` at one of the three event points: set at line 241, read-clear, or clear at line 261. A read coincident with the set point, a late enable during blanking and a read in mid-frame are each placed on purpose, so a priority mistake shows within one clock of that stimulus.

// File: rtl/raster_timing_pkg.sv
package raster_timing_pkg;

  // Increment with wrap to zero after period-1.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned period);
    return (v == period - 1) ? 0 : v + 1;
  endfunction

  // Position match on a (dot, line) pair.
  function automatic logic at_pos(input int unsigned d, input int unsigned l,
                                  input int unsigned want_d, input int unsigned want_l);
    return (d == want_d) && (l == want_l);
  endfunction

endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
  parameter int DOTS_PER_LINE   = 341,
  parameter int LINES_PER_FRAME = 262,
  parameter int DW              = 9,
  parameter int LW              = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] dot_q,
  output logic [LW-1:0] line_q,
  output logic [DW-1:0] dot_nx,
  output logic [LW-1:0] line_nx,
  output logic          end_of_line
);
  import raster_timing_pkg::*;

  always_comb begin
    end_of_line = (32'(dot_q) == DOTS_PER_LINE - 1);
    dot_nx      = DW'(wrap_inc(32'(dot_q), DOTS_PER_LINE));
    line_nx     = end_of_line ? LW'(wrap_inc(32'(line_q), LINES_PER_FRAME)) : line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q  <= '0;
      line_q <= '0;
    end else begin
      dot_q  <= dot_nx;
      line_q <= line_nx;
    end
  end
endmodule

// File: rtl/vbl_status_flag.sv
module vbl_status_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  input  logic rd_clr,
  output logic flag_q
);
  // Priority: set over end-of-frame clear over read clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_ev) flag_q <= 1'b1;
    else if (clr_ev) flag_q <= 1'b0;
    else if (rd_clr) flag_q <= 1'b0;
  end
endmodule

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int DOTS_PER_LINE   = 341,
  parameter int LINES_PER_FRAME = 262,
  parameter int VISIBLE_DOTS    = 256,
  parameter int LAST_PIC_LINE   = 240,
  parameter int VBL_LINE        = 241,
  parameter int VBL_DOT         = 1,
  localparam int DW = $clog2(DOTS_PER_LINE),
  localparam int LW = $clog2(LINES_PER_FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nmi_enable,
  input  logic          status_rd,
  output logic [DW-1:0] dot,
  output logic [LW-1:0] line,
  output logic          visible,
  output logic          vblank,
  output logic          vbl_status,
  output logic          nmi_n
);
  import raster_timing_pkg::*;

  logic [DW-1:0] dot_nx;
  logic [LW-1:0] line_nx;
  logic          end_of_line;
  logic          set_ev;
  logic          clr_ev;

  raster_counter #(
    .DOTS_PER_LINE  (DOTS_PER_LINE),
    .LINES_PER_FRAME(LINES_PER_FRAME),
    .DW             (DW),
    .LW             (LW)
  ) cnt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .dot_q      (dot),
    .line_q     (line),
    .dot_nx     (dot_nx),
    .line_nx    (line_nx),
    .end_of_line(end_of_line)
  );

  // Events are decoded from the next position so the flag changes
  // in the same cycle the counters show the event position.
  always_comb begin
    set_ev  = at_pos(32'(dot_nx), 32'(line_nx), VBL_DOT, VBL_LINE);
    clr_ev  = at_pos(32'(dot_nx), 32'(line_nx), 0, LINES_PER_FRAME - 1);
    visible = (32'(dot) < VISIBLE_DOTS) && (32'(line) <= LAST_PIC_LINE);
    vblank  = (32'(line) >= VBL_LINE);
  end

  vbl_status_flag flag_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set_ev(set_ev),
    .clr_ev(clr_ev),
    .rd_clr(status_rd),
    .flag_q(vbl_status)
  );

  assign nmi_n = ~(vbl_status & nmi_enable);
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int DOTS_PER_LINE   = 341,
  parameter int LINES_PER_FRAME = 262,
  parameter int VBL_LINE        = 241,
  parameter int VBL_DOT         = 1,
  parameter int DW              = 9,
  parameter int LW              = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nmi_enable,
  input logic          status_rd,
  input logic [DW-1:0] dot,
  input logic [LW-1:0] line,
  input logic          visible,
  input logic          vblank,
  input logic          vbl_status,
  input logic          nmi_n,
  input logic          end_of_line
);
  localparam logic [DW-1:0] LAST_DOT  = DW'(DOTS_PER_LINE - 1);
  localparam logic [LW-1:0] LAST_LINE = LW'(LINES_PER_FRAME - 1);
  localparam logic [LW-1:0] SET_LINE  = LW'(VBL_LINE);
  localparam logic [DW-1:0] SET_DOT   = DW'(VBL_DOT);

  a_r2_dot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (dot == LAST_DOT) |=> (dot == '0));

  a_r2_dot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dot != LAST_DOT) |=> (dot == $past(dot) + 1'b1) && $stable(line));

  a_r3_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (end_of_line && line == LAST_LINE) |=> (line == '0));

  a_r5_status_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    vbl_status |-> vblank);

  a_r4_visible_not_blank: assert property (@(posedge clk) disable iff (!rst_n)
    visible |-> !vblank);

  a_r6_set_point: assert property (@(posedge clk) disable iff (!rst_n)
    (line == SET_LINE && dot == SET_DOT) |-> vbl_status);

  a_r7_frame_end_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (line == LAST_LINE && dot == '0) |-> !vbl_status);

  a_r8_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !(line == SET_LINE && dot == SET_DOT - 1'b1)) |=> !vbl_status);

  a_r9_late_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nmi_enable) && vbl_status) |-> !nmi_n);

  a_r9_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !vbl_status |-> nmi_n);
endmodule

bind raster_timing raster_timing_chk #(
  .DOTS_PER_LINE  (DOTS_PER_LINE),
  .LINES_PER_FRAME(LINES_PER_FRAME),
  .VBL_LINE       (VBL_LINE),
  .VBL_DOT        (VBL_DOT),
  .DW             (DW),
  .LW             (LW)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .nmi_enable (nmi_enable),
  .status_rd  (status_rd),
  .dot        (dot),
  .line       (line),
  .visible    (visible),
  .vblank     (vblank),
  .vbl_status (vbl_status),
  .nmi_n      (nmi_n),
  .end_of_line(end_of_line)
);

// File: tb/raster_timing_tb.sv
module raster_timing_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nmi_enable = 1'b0;
  logic       status_rd = 1'b0;
  logic [8:0] dot, line;
  logic       visible, vblank, vbl_status, nmi_n;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference model state
  int  m_dot = 0, m_line = 0;
  bit  m_flag = 0;
  bit  model_run = 0;

  always #4 clk = ~clk;  // 125 MHz

  raster_timing dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_enable(nmi_enable), .status_rd(status_rd),
    .dot(dot), .line(line), .visible(visible), .vblank(vblank),
    .vbl_status(vbl_status), .nmi_n(nmi_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at model line %0d dot %0d: actual %0d expected %0d",
               tag, m_line, m_dot, act, exp);
    end
  endtask

  // Behavioural model: advance position, then apply flag events.
  always @(posedge clk) begin
    cycles++;
    if (model_run) begin
      bit rd_now;
      rd_now = status_rd;
      m_dot++;
      if (m_dot == 341) begin
        m_dot = 0;
        m_line++;
        if (m_line == 262) m_line = 0;
      end
      if (m_line == 241 && m_dot == 1)      m_flag = 1;      // R6
      else if (m_line == 261 && m_dot == 0) m_flag = 0;      // R7
      else if (rd_now)                      m_flag = 0;      // R8
    end
  end

  task automatic compare_all();
    chk("R2 dot", int'(dot), m_dot);
    chk("R3 line", int'(line), m_line);
    chk("R4 visible", int'(visible), int'(m_dot < 256 && m_line <= 240));
    chk("R5 vblank", int'(vblank), int'(m_line >= 241));
    chk("R6/R7/R8 vbl_status", int'(vbl_status), int'(m_flag));
    chk("R9 nmi_n", int'(nmi_n), int'(!(m_flag && nmi_enable)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset dot", int'(dot), 0);
    chk("R1 reset line", int'(line), 0);
    chk("R1 reset status", int'(vbl_status), 0);
    chk("R1 reset nmi_n", int'(nmi_n), 1);
    @(negedge clk);
    rst_n = 1'b1;
    model_run = 1;
    for (int f = 0; f < 2; f++) begin
      for (int n = 0; n < 341 * 262; n++) begin
        @(negedge clk);
        // stimulus chosen from the model's position for the next edge
        status_rd = 1'b0;
        if (f == 0) begin
          nmi_enable = (m_line >= 250);
          if (m_line == 241 && m_dot == 0) status_rd = 1'b1;   // R6: set wins
          if (m_line == 255 && m_dot == 5) status_rd = 1'b1;   // R8
        end else begin
          nmi_enable = 1'b1;
          if (m_line == 100 && m_dot == 7) status_rd = 1'b1;   // R10
        end
        #1;
        compare_all();
        if (f == 0 && m_line == 250 && m_dot == 0)
          chk("R9 late enable asserts nmi_n", int'(nmi_n), 0);
        if (f == 1 && m_line == 100 && m_dot == 9)
          chk("R10 mid-frame read no effect", int'(vbl_status), 0);
        if (m_line == 241 && m_dot == 1)
          chk("R6 set despite coincident read", int'(vbl_status), 1);
        if (f == 1 && m_line == 261 && m_dot == 0)
          chk("R7 end-of-frame clear", int'(vbl_status), 0);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles >= 195000);
    fails++;
    $display("FAIL watchdog expired: actual %0d cycles expected fewer", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule